// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter for a small controller. Its count source is either the instruction cycle or an external clock pin. The system clock is divided into four quarter-phases, and four system clocks make one instruction cycle. The chosen source can be inverted by an edge-select bit, so that the counter advances on rising or on falling transitions. The source can also pass through a hidden power-of-two prescaler. The prescaled level is sampled on the second and fourth quarter-phases. A rising edge of that sampled level advances the count by one.

Software programs the block through two write ports. One port loads a 7-bit control word and the other loads the count. Both values read back. When the count rolls over from 0xFF to 0x00, a sticky overflow flag is set. Only an explicit clear strobe removes the flag. The interrupt output carries the flag when the interrupt-enable bit is set.

Top module: `tick_counter8`

## Requirements
- R1: After reset, the count, the control word, the overflow flag and the interrupt output are all zero.
- R2: With control bit 5 = 0 (internal source) and bit 3 = 1 (prescaler bypassed), the count advances by exactly one per four system clocks. Setting bit 4 (invert) leaves this rate unchanged.
- R3: With bit 3 = 0, the rate field in bits 2:0 holds a code k. The source is then divided by 2^(k+1), giving 1:2 for code 0 up to 1:256 for code 7. This applies to both sources.
- R4: With bit 5 = 1, each selected edge of the external pin advances the count once. Bit 4 = 0 selects the rising edge and bit 4 = 1 selects the falling edge.
- R5: A count write takes effect at the next clock edge and overrides any increment in that cycle. It clears the hidden prescaler to zero. The count then holds for eight system clocks after the write.
- R6: An increment that wraps the count from 0xFF to 0x00 sets the overflow flag, whether or not the interrupt is enabled. Writing 0x00 to the count does not set the flag.
- R7: The overflow flag stays set until a flag_clr strobe arrives. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R8: The irq output is high exactly when the overflow flag is set and control bit 6 (interrupt enable) is 1.
- R9: ctrl_q returns the last value written through ctrl_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; four cycles make one instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | External count input, asynchronous |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 7 | Control word: [2:0] rate, [3] bypass, [4] invert, [5] external, [6] irq enable |
| ctrl_q | output | 7 | Control word readback |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| cnt_q | output | 8 | Current count |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The internal source is run through a table of prescaler settings: bypass, several rate codes and the inverted polarity. Each entry is measured over a whole number of periods, so a wrong divider or a wrong rate index gives a different count delta. The external pin is driven with single transitions in both polarities, which separates rising-edge counting from falling-edge counting, and with a pulse train through the 1:2 prescaler. Two count writes placed a known distance apart show whether the prescaler was really cleared: a stale prescaler would advance the count early. The overflow tests separate the flag from the interrupt by enabling the interrupt only after the wrap.

// File: rtl/tick_counter8.sv
module tick_counter8 #(
  parameter int CW = 8,
  parameter int HOLD_CLKS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk,
  input  logic          ctrl_we,
  input  logic [6:0]    ctrl_wdata,
  output logic [6:0]    ctrl_q,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt_q,
  input  logic          flag_clr,
  output logic          ovf_flag,
  output logic          irq
);
  localparam int HW = $clog2(HOLD_CLKS + 1);

  logic [1:0]    phase;
  logic [1:0]    ext_s;
  logic          src_d, samp, samp_d;
  logic [7:0]    psc;
  logic [HW-1:0] hold;

  wire use_ext  = ctrl_q[5];
  wire src_lvl  = (use_ext ? ext_s[1] : phase[1]) ^ ctrl_q[4];
  wire src_rise = src_lvl & ~src_d;
  wire psc_out  = ctrl_q[3] ? src_lvl : psc[ctrl_q[2:0]];
  wire tick     = samp & ~samp_d;
  wire inc      = tick && (hold == '0) && !cnt_we;
  wire wrap     = inc && (cnt_q == {CW{1'b1}});

  assign irq = ovf_flag & ctrl_q[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      ext_s  <= '0;
      src_d  <= 1'b0;
      samp   <= 1'b0;
      samp_d <= 1'b0;
    end else begin
      phase  <= phase + 2'd1;
      ext_s  <= {ext_s[0], ext_clk};
      src_d  <= src_lvl;
      samp_d <= samp;
      if (phase[0]) samp <= psc_out;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       psc <= '0;
    else if (cnt_we)  psc <= '0;
    else if (src_rise) psc <= psc + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             hold <= '0;
    else if (cnt_we)        hold <= HW'(HOLD_CLKS);
    else if (hold != '0)    hold <= hold - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wdata;
      if (cnt_we)  cnt_q <= cnt_wdata;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      if (wrap)          ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_counter8_props.sv
module tick_counter8_props (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_we,
  input logic [7:0] cnt_wdata,
  input logic [7:0] cnt_q,
  input logic       flag_clr,
  input logic       ovf_flag,
  input logic       irq
);
  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));

  assert_hold_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_we) && !cnt_we) |=> (cnt_we || $stable(cnt_q)));

  assert_step_of_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_we) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));

  assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_we) && $past(cnt_q) == 8'hFF && cnt_q == 8'h00) |-> ovf_flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(flag_clr));

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

bind tick_counter8 tick_counter8_props u_props (
  .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .cnt_q(cnt_q), .flag_clr(flag_clr), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/test_tick_counter8.sv
module test_tick_counter8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [6:0] ctrl_wdata = '0;
  logic [6:0] ctrl_q;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_q;
  logic       flag_clr = 1'b0;
  logic       ovf_flag;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_counter8 i_tick_counter8 (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .irq(irq)
  );

  // {ctrl[6:0] in bits 30:24, window length in clocks, expected delta}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h08, 16'd20,   8'd5},  // R2 bypass
    {8'h18, 16'd20,   8'd5},  // R2 inverted
    {8'h00, 16'd24,   8'd3},  // R3 code 0
    {8'h01, 16'd48,   8'd3},  // R3 code 1
    {8'h02, 16'd96,   8'd3},  // R3 code 2
    {8'h03, 16'd128,  8'd2},  // R3 code 3
    {8'h05, 16'd512,  8'd2},  // R3 code 5
    {8'h07, 16'd2048, 8'd2}   // R3 code 7
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_ctrl(input logic [6:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; step(1); ctrl_we = 1'b0;
  endtask

  task automatic put_cnt(input logic [7:0] v);
    cnt_we = 1'b1; cnt_wdata = v; step(1); cnt_we = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; step(8);
      ext_clk = 1'b0; step(8);
    end
  endtask

  initial begin
    step(3);
    check("R1 count", cnt_q, 0);
    check("R1 ctrl", ctrl_q, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    step(2);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] c0;
      int per;
      per = 4 * (VEC[v][27] ? 1 : (2 << VEC[v][26:24]));
      put_ctrl(VEC[v][30:24]);
      check("R9", ctrl_q, VEC[v][30:24]);
      put_cnt(8'h00);
      step(per + 16);
      c0 = cnt_q;
      step(int'(VEC[v][23:8]));
      check(VEC[v][27] ? "R2 rate" : "R3 rate", 8'(cnt_q - c0), VEC[v][7:0]);
    end

    // R5: write priority and hold window
    put_ctrl(7'h08);
    step(5);
    put_cnt(8'h5A);
    check("R5 load", cnt_q, 8'h5A);
    step(6);
    check("R5 hold", cnt_q, 8'h5A);

    // R5: prescaler cleared by write (1:256, 512 clocks to first step)
    put_ctrl(7'h07);
    put_cnt(8'h10);
    step(300);
    put_cnt(8'h20);
    step(400);
    check("R5 psc clear", cnt_q, 8'h20);
    step(160);
    check("R5 psc clear", cnt_q, 8'h21);

    // R4: external rising
    ext_clk = 1'b0;
    put_ctrl(7'h28);
    put_cnt(8'h00);
    step(12);
    ext_clk = 1'b1; step(12);
    check("R4 rising", cnt_q, 1);
    ext_clk = 1'b0; step(12);
    check("R4 rising", cnt_q, 1);
    pulse_ext(2);
    step(8);
    check("R4 rising", cnt_q, 3);

    // R4: external falling
    put_ctrl(7'h38);
    put_cnt(8'h00);
    step(12);
    ext_clk = 1'b1; step(12);
    check("R4 falling", cnt_q, 0);
    ext_clk = 1'b0; step(12);
    check("R4 falling", cnt_q, 1);

    // R3: external through 1:2 prescaler
    put_ctrl(7'h20);
    put_cnt(8'h00);
    step(12);
    pulse_ext(4);
    step(8);
    check("R3 ext 1:2", cnt_q, 2);

    // R6/R7/R8: overflow
    put_ctrl(7'h08);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    put_cnt(8'h00);
    step(4);
    check("R6 write 00", ovf_flag, 0);
    put_cnt(8'hFE);
    step(40);
    check("R6 flag", ovf_flag, 1);
    check("R8 masked", irq, 0);
    put_ctrl(7'h48);
    check("R8 enabled", irq, 1);
    step(20);
    check("R7 sticky", ovf_flag, 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    check("R7 clear", ovf_flag, 0);
    check("R8 clear", irq, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule